// File: doc/BRIEF.md
# Page Write Merge Buffer

This block models the page-level data path of a paged non-volatile memory. A small behavioural array, organised as pages of bytes, stands in for the storage cells. A client opens a sequence with a start pulse that names the target page, a starting byte offset and a mode. It then streams in bytes, each marked valid, and closes the sequence with a commit pulse.

In write mode the commit turns a partial page update into a fixed sequence. First a merge pass reads the addressed page and fills every buffer slot the client left untouched. Then an erase pass sets the whole page to all ones. Last, a program pass copies the full buffer into the page. In program-only mode there is no erase pass: the merge pass ANDs each loaded byte with the stored byte, so bits can only fall from 1 to 0. A busy flag covers the whole internal sequence, and a one-cycle done pulse marks its end. A registered read port lets the surrounding logic inspect any byte of the array while the block is idle.

Top module: `pgwr_merge`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0 and no sequence is open. Reset leaves the array contents untouched, and the array powers up with every byte at 8'hFF.
- R2: A `start_i` pulse while not busy opens a sequence for `page_i`, `offset_i` and `mode_i` (0 = write, 1 = program-only). Each later cycle with `valid_i` high stores `data_i` at the next offset, beginning at `offset_i`.
- R3: After the byte at the last offset of the page, the write offset wraps to 0 of the same page.
- R4: If one offset receives more than one byte in a sequence, the byte received last is the one committed.
- R5: On commit in write mode, each loaded offset of the page takes exactly the loaded byte, including bits that go from 0 to 1. Every other offset keeps its previous value.
- R6: On commit in program-only mode, each loaded offset becomes the old byte AND the loaded byte. Every other offset keeps its previous value, and no erase pass runs.
- R7: `busy_o` rises on the clock edge that accepts `commit_i`. It stays high for (BYTES+1+MERGE_EXTRA)+(BYTES+ERASE_EXTRA)+(BYTES+PROG_EXTRA) cycles in write mode, and for the same total without the erase term in program-only mode. `done_o` is high for exactly the one cycle in which `busy_o` has just fallen.
- R8: While `busy_o` is high, `start_i`, `valid_i` and `commit_i` have no effect.
- R9: A commit with no bytes loaded runs the full sequence with busy and done, and leaves the page unchanged.
- R10: A commit changes only the addressed page. All other pages keep their contents.
- R11: `valid_i` and `commit_i` have no effect when no sequence is open, including after a reset that closes an open sequence.
- R12: While not busy, `rd_data_o` shows the byte at (`rd_page_i`, `rd_off_i`) one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Open a new write sequence |
| page_i | input | PG_W | Target page for the sequence |
| offset_i | input | OFF_W | First byte offset inside the page |
| mode_i | input | 1 | 0 = write (merge, erase, program), 1 = program-only |
| valid_i | input | 1 | `data_i` holds a byte to load |
| data_i | input | DATA_W | Byte to load |
| commit_i | input | 1 | Close the sequence and start the internal passes |
| rd_page_i | input | PG_W | Page of the inspection read |
| rd_off_i | input | OFF_W | Offset of the inspection read |
| rd_data_o | output | DATA_W | Registered inspection read data |
| busy_o | output | 1 | Internal passes in progress |
| done_o | output | 1 | One-cycle pulse when the last pass ends |

## Verification
The bench builds the block with 16-byte pages, 4 pages, and extra pass cycles of 2, 3 and 1. This keeps a full sequence to a few dozen cycles, so it can compare the whole array after every commit. With 16-byte pages, offset wrap and double loading of the same offset come within reach of streams of twenty bytes. Different extra counts for each pass make the expected busy lengths differ between the two modes, so a skipped or added pass shows up directly in the busy count.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_MERGE = 3'd2,
    ST_ERASE = 3'd3,
    ST_PROG  = 3'd4
  } pgwr_state_e;

  localparam logic MODE_WRITE = 1'b0;
  localparam logic MODE_PROG  = 1'b1;
endpackage

// File: rtl/pgwr_array.sv
module pgwr_array #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 11,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // storage comes up erased
  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
    rdata_q <= cells[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
  parameter int BYTES  = 256,
  parameter int DATA_W = 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic              mark_i,
  input  logic [OFF_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFF_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rmask_o
);
  logic [DATA_W-1:0] slots [BYTES];
  logic [BYTES-1:0]  loaded_q;

  always_ff @(posedge clk) begin
    if (we_i) slots[widx_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) loaded_q <= '0;
    else if (we_i && mark_i) loaded_q[widx_i] <= 1'b1;
  end

  assign rdata_o = slots[ridx_i];
  assign rmask_o = loaded_q[ridx_i];

  AST_MARK_RECORDED: assert property (@(posedge clk) disable iff (rst)
    (we_i && mark_i && !clr_i) |=> loaded_q[$past(widx_i)]); // R2
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int BYTES       = 256,
  parameter int PAGES       = 8,
  parameter int DATA_W      = 8,
  parameter int MERGE_EXTRA = 0,
  parameter int ERASE_EXTRA = 0,
  parameter int PROG_EXTRA  = 0,
  localparam int OFF_W  = $clog2(BYTES),
  localparam int PG_W   = $clog2(PAGES),
  localparam int ADDR_W = PG_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [PG_W-1:0]   page_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              mode_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  input  logic [PG_W-1:0]   rd_page_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  // page buffer side
  output logic              b_clr_o,
  output logic              b_we_o,
  output logic              b_mark_o,
  output logic [OFF_W-1:0]  b_widx_o,
  output logic [DATA_W-1:0] b_wdata_o,
  output logic [OFF_W-1:0]  b_ridx_o,
  input  logic [DATA_W-1:0] b_rdata_i,
  input  logic              b_rmask_i,
  // array side
  output logic              a_we_o,
  output logic [ADDR_W-1:0] a_waddr_o,
  output logic [DATA_W-1:0] a_wdata_o,
  output logic [ADDR_W-1:0] a_raddr_o,
  input  logic [DATA_W-1:0] a_rdata_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam int MERGE_LEN = BYTES + 1 + MERGE_EXTRA;
  localparam int ERASE_LEN = BYTES + ERASE_EXTRA;
  localparam int PROG_LEN  = BYTES + PROG_EXTRA;
  localparam int CNT_W = $clog2(BYTES + 2 + MERGE_EXTRA + ERASE_EXTRA + PROG_EXTRA);
  localparam logic [CNT_W-1:0] MERGE_LAST = CNT_W'(MERGE_LEN - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_LEN - 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_BYTES  = CNT_W'(BYTES);

  pgwr_state_e       state_q;
  logic [PG_W-1:0]   page_q;
  logic [OFF_W-1:0]  ptr_q;
  logic              mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q;

  logic accept_start, load_byte, do_commit, merge_cap, pass_walk, prog_end;
  logic [OFF_W-1:0] merge_idx;

  assign accept_start = start_i && (state_q == ST_IDLE || state_q == ST_LOAD);
  assign load_byte    = (state_q == ST_LOAD) && valid_i && !start_i;
  assign do_commit    = (state_q == ST_LOAD) && commit_i && !start_i;
  assign merge_cap    = (state_q == ST_MERGE) && (cnt_q != '0) && (cnt_q <= CNT_BYTES);
  assign merge_idx    = OFF_W'(cnt_q - 1'b1);
  assign pass_walk    = (state_q == ST_ERASE || state_q == ST_PROG) && (cnt_q < CNT_BYTES);
  assign prog_end     = (state_q == ST_PROG) && (cnt_q == PROG_LAST);

  // buffer write: loading from the stream, or merge fill from the array
  always_comb begin
    b_clr_o   = accept_start;
    b_we_o    = load_byte || merge_cap;
    b_mark_o  = load_byte;
    b_widx_o  = load_byte ? ptr_q : merge_idx;
    b_ridx_o  = (state_q == ST_MERGE) ? merge_idx : cnt_q[OFF_W-1:0];
    if (load_byte)           b_wdata_o = data_i;
    else if (!b_rmask_i)     b_wdata_o = a_rdata_i;
    else if (mode_q == MODE_PROG) b_wdata_o = a_rdata_i & b_rdata_i;
    else                     b_wdata_o = b_rdata_i;
  end

  always_comb begin
    a_we_o    = pass_walk;
    a_waddr_o = {page_q, cnt_q[OFF_W-1:0]};
    a_wdata_o = (state_q == ST_ERASE) ? {DATA_W{1'b1}} : b_rdata_i;
    a_raddr_o = (state_q == ST_MERGE) ? {page_q, cnt_q[OFF_W-1:0]}
                                      : {rd_page_i, rd_off_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      ptr_q   <= '0;
      mode_q  <= MODE_WRITE;
      cnt_q   <= '0;
    end else begin
      if (accept_start) begin
        state_q <= ST_LOAD;
        page_q  <= page_i;
        ptr_q   <= offset_i;
        mode_q  <= mode_i;
      end else begin
        case (state_q)
          ST_LOAD: begin
            if (load_byte) ptr_q <= ptr_q + 1'b1;
            if (do_commit) begin
              state_q <= ST_MERGE;
              cnt_q   <= '0;
            end
          end
          ST_MERGE: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == MERGE_LAST) begin
              cnt_q   <= '0;
              state_q <= (mode_q == MODE_PROG) ? ST_PROG : ST_ERASE;
            end
          end
          ST_ERASE: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == ERASE_LAST) begin
              cnt_q   <= '0;
              state_q <= ST_PROG;
            end
          end
          ST_PROG: begin
            cnt_q <= cnt_q + 1'b1;
            if (prog_end) begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= prog_end;
      if (do_commit)     busy_q <= 1'b1;
      else if (prog_end) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R7
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q); // R7
  AST_NO_ERASE_IN_PROG: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERASE) |-> (mode_q == MODE_WRITE)); // R6
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i) |=> $stable(page_q)); // R8
endmodule

// File: rtl/pgwr_merge.sv
module pgwr_merge #(
  parameter int BYTES       = 256,
  parameter int PAGES       = 8,
  parameter int DATA_W      = 8,
  parameter int MERGE_EXTRA = 0,
  parameter int ERASE_EXTRA = 0,
  parameter int PROG_EXTRA  = 0,
  localparam int OFF_W  = $clog2(BYTES),
  localparam int PG_W   = $clog2(PAGES),
  localparam int ADDR_W = PG_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [PG_W-1:0]   page_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              mode_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  input  logic [PG_W-1:0]   rd_page_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              b_clr, b_we, b_mark, b_rmask;
  logic [OFF_W-1:0]  b_widx, b_ridx;
  logic [DATA_W-1:0] b_wdata, b_rdata;
  logic              a_we;
  logic [ADDR_W-1:0] a_waddr, a_raddr;
  logic [DATA_W-1:0] a_wdata, a_rdata;

  pgwr_ctrl #(
    .BYTES(BYTES), .PAGES(PAGES), .DATA_W(DATA_W),
    .MERGE_EXTRA(MERGE_EXTRA), .ERASE_EXTRA(ERASE_EXTRA), .PROG_EXTRA(PROG_EXTRA)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .start_i(start_i), .page_i(page_i), .offset_i(offset_i), .mode_i(mode_i),
    .valid_i(valid_i), .data_i(data_i), .commit_i(commit_i),
    .rd_page_i(rd_page_i), .rd_off_i(rd_off_i),
    .b_clr_o(b_clr), .b_we_o(b_we), .b_mark_o(b_mark), .b_widx_o(b_widx),
    .b_wdata_o(b_wdata), .b_ridx_o(b_ridx), .b_rdata_i(b_rdata), .b_rmask_i(b_rmask),
    .a_we_o(a_we), .a_waddr_o(a_waddr), .a_wdata_o(a_wdata), .a_raddr_o(a_raddr),
    .a_rdata_i(a_rdata),
    .busy_o(busy_o), .done_o(done_o)
  );

  pgwr_buffer #(.BYTES(BYTES), .DATA_W(DATA_W)) u_buffer (
    .clk(clk), .rst(rst), .clr_i(b_clr), .we_i(b_we), .mark_i(b_mark),
    .widx_i(b_widx), .wdata_i(b_wdata), .ridx_i(b_ridx),
    .rdata_o(b_rdata), .rmask_o(b_rmask)
  );

  pgwr_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we_i(a_we), .waddr_i(a_waddr), .wdata_i(a_wdata),
    .raddr_i(a_raddr), .rdata_o(a_rdata)
  );

  assign rd_data_o = a_rdata;

  AST_ARRAY_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
    a_we |-> busy_o); // R11
  AST_LOAD_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (b_we && b_mark) |-> !busy_o); // R8
endmodule

// File: tb/test_pgwr_merge.sv
`timescale 1ns/1ps
module test_pgwr_merge;
  localparam int BYTES = 16;
  localparam int PAGES = 4;
  localparam int MEX = 2;
  localparam int EEX = 3;
  localparam int PEX = 1;
  localparam int OFF_W = $clog2(BYTES);
  localparam int PG_W = $clog2(PAGES);
  localparam int BUSY_WR = (BYTES + 1 + MEX) + (BYTES + EEX) + (BYTES + PEX);
  localparam int BUSY_PR = (BYTES + 1 + MEX) + (BYTES + PEX);

  // vector fields: mode, page, offset, count, seed
  localparam int NVEC = 7;
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd0, 8'd0, 8'd0,  8'd16, 8'hA5},  // full page write
    {8'd0, 8'd1, 8'd5,  8'd3,  8'h3C},  // partial write, merge
    {8'd0, 8'd0, 8'd14, 8'd5,  8'h11},  // wrap R3
    {8'd1, 8'd1, 8'd4,  8'd4,  8'hF0},  // program-only R6
    {8'd0, 8'd2, 8'd0,  8'd1,  8'h00},  // single byte
    {8'd1, 8'd0, 8'd0,  8'd16, 8'h0F},  // program-only full page
    {8'd0, 8'd3, 8'd7,  8'd20, 8'h77}   // repeat offsets R4
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, mode_i = 0, valid_i = 0, commit_i = 0;
  logic [PG_W-1:0] page_i = '0, rd_page_i = '0;
  logic [OFF_W-1:0] offset_i = '0, rd_off_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] rd_data_o;
  logic busy_o, done_o;

  always #2.5 clk = ~clk;

  pgwr_merge #(
    .BYTES(BYTES), .PAGES(PAGES), .DATA_W(8),
    .MERGE_EXTRA(MEX), .ERASE_EXTRA(EEX), .PROG_EXTRA(PEX)
  ) i_pgwr_merge (
    .clk(clk), .rst(rst), .start_i(start_i), .page_i(page_i), .offset_i(offset_i),
    .mode_i(mode_i), .valid_i(valid_i), .data_i(data_i), .commit_i(commit_i),
    .rd_page_i(rd_page_i), .rd_off_i(rd_off_i), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [7:0] model [PAGES*BYTES];

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int k);
    return seed + 8'(k * 29);
  endfunction

  // compare the whole array against the model, one check per page
  task automatic check_pages(input string req);
    for (int p = 0; p < PAGES; p++) begin
      int bad = -1;
      logic [7:0] got = '0;
      for (int o = 0; o < BYTES; o++) begin
        rd_page_i = PG_W'(p);
        rd_off_i  = OFF_W'(o);
        @(negedge clk);
        if (bad < 0 && rd_data_o !== model[p*BYTES+o]) begin
          bad = o;
          got = rd_data_o;
        end
      end
      if (bad < 0) chk(req, 0, 0);
      else chk($sformatf("%s page %0d off %0d", req, p, bad), got, model[p*BYTES+bad]);
    end
  endtask

  task automatic run_op(input bit mode, input int page, input int off, input int count,
                        input logic [7:0] seed, input bit noise, input string req);
    logic [7:0] nb [BYTES];
    bit         nm [BYTES];
    int busy_n = 0;
    for (int j = 0; j < BYTES; j++) nm[j] = 0;
    start_i = 1; page_i = PG_W'(page); offset_i = OFF_W'(off); mode_i = mode;
    @(negedge clk);
    start_i = 0;
    for (int k = 0; k < count; k++) begin
      valid_i = 1; data_i = dbyte(seed, k);
      nb[(off + k) % BYTES] = data_i;
      nm[(off + k) % BYTES] = 1;
      @(negedge clk);
    end
    valid_i = 0;
    commit_i = 1;
    @(negedge clk);
    commit_i = 0;
    for (int j = 0; j < BYTES; j++)
      if (nm[j]) model[page*BYTES+j] = mode ? (model[page*BYTES+j] & nb[j]) : nb[j];
    while (busy_o === 1'b1 && busy_n < 1000) begin
      busy_n++;
      if (noise && busy_n == 2) begin
        start_i = 1; page_i = PG_W'((page + 1) % PAGES); offset_i = '0; mode_i = 0;
        valid_i = 1; data_i = 8'h00; commit_i = 1;
      end
      if (busy_n == 6) begin
        start_i = 0; valid_i = 0; commit_i = 0;
      end
      @(negedge clk);
    end
    start_i = 0; valid_i = 0; commit_i = 0;
    chk({req, " R7 busy length"}, busy_n, mode ? BUSY_PR : BUSY_WR);
    chk("R7 done at busy fall", done_o, 1);
    @(negedge clk);
    chk("R7 done single cycle", done_o, 0);
    chk("R8 no sequence after busy noise", busy_o, 0);
    check_pages({req, " R5 R6 R10 R12 contents"});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < PAGES*BYTES; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 done in reset", done_o, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 busy after reset", busy_o, 0);
    check_pages("R1 erased at power-up");

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [39:0] e = VEC[v];
      run_op(e[32], int'(e[31:24]), int'(e[23:16]), int'(e[15:8]), e[7:0],
             (v == 1 || v == 3), $sformatf("R2 vec%0d", v));
    end

    // R9: commit with nothing loaded, both modes
    run_op(1'b0, 1, 0, 0, 8'h00, 1'b0, "R9 empty write");
    run_op(1'b1, 3, 0, 0, 8'h00, 1'b0, "R9 empty program");

    // R11: stream and commit with no open sequence
    valid_i = 1; data_i = 8'h00; commit_i = 1;
    @(negedge clk);
    valid_i = 0; commit_i = 0;
    @(negedge clk);
    chk("R11 idle commit ignored", busy_o, 0);

    // R1 R11: reset closes an open sequence, array kept
    start_i = 1; page_i = 2; offset_i = 3; mode_i = 0;
    @(negedge clk);
    start_i = 0; valid_i = 1; data_i = 8'h42;
    @(negedge clk);
    valid_i = 0; rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    commit_i = 1;
    @(negedge clk);
    commit_i = 0;
    @(negedge clk);
    chk("R11 commit after reset ignored", busy_o, 0);
    check_pages("R1 reset keeps array");

    // R3 R4 R5: restart write on page 2 with 0-to-1 bits and double wrap
    run_op(1'b0, 2, 15, 33, 8'h5A, 1'b0, "R3 R4 double wrap");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule